// File: doc/BRIEF.md
# Dithered Fractional Clock Divider

This block derives one output clock from its own input clock, which acts as the fine-step (quarter) clock of the parent reference. Each output half-period is a whole number of input cycles. The count is made of three parts: a coarse part, held as the state of an 11-bit shift-register sequence rather than as a binary number; a 2-bit fine part; and one optional extra cycle. A signed error accumulator, fed by a non-negative up-increment and a non-positive down-increment, decides on each half-period whether that extra cycle is added. The long-run output rate is therefore exact: f_out = f_clk·(up−dn) / (2·(D·(up−dn)+up)), where D is the base half-period in input cycles.

Software programs four word registers through a simple select-based write port and can read them back on a separate select. Clearing the enable bit stops the output low at once. Changing the divider or the increments while running is safe, because new values are sampled only when a half-period starts.

Top module: `fnco_clkdiv`

## Requirements
- R1: After reset clk_out is 0 and all four registers read back as 0.
- R2: Word select 0 is control: only bit 31 (enable) is stored, and other bits read 0. Select 1 is the divider: bits [1:0] are the fine field, bits [12:2] are the coarse state, and bits above 12 read 0. Select 2 is the up-increment and select 3 is the down-increment; both are full 32-bit two's-complement values that read back unchanged.
- R3: A coarse state S is decoded as the number n of sequence steps needed to get from S to 0x7FF. One step is next = (S >> 1) XOR (0x500 if S[0] else 0). The coarse value is C = n + 3, and the base half-period is D = 4·C + fine input cycles.
- R4: The accumulator starts at 0 when the output starts. At the start of every half-period, if the accumulator is ≥ 0, that half-period lasts D+1 cycles and the down-increment is added. Otherwise it lasts D cycles and the up-increment is added.
- R5: After the enable write, clk_out stays low for one cycle plus the first half-period, then rises.
- R6: If up < 0, or dn > 0, or both are 0, or the coarse state is 0, then clk_out stays 0 while enabled.
- R7: Once enable is cleared, clk_out is 0 within two clock edges of the write. A later enable starts again from an accumulator value of 0.
- R8: Divider and increment values are sampled only on the edge that starts a half-period. A write landing on that same edge takes effect one half-period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (fine-step) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 2 | Word select for the write (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 2 | Word select for readback |
| reg_rdata | output | 32 | Readback data (combinational) |
| clk_out | output | 1 | Divided output clock |

## Verification
A register write and a half-period start can fall on the same clock edge. In that case the start must use the old register contents, and the new value must apply only from the following half-period. The bench locks onto an observed output edge and counts forward, so that the divider write is sampled exactly on the next start edge. It then repeats the test one cycle earlier. Each case is judged by the measured lengths of the next three half-periods: old, old, new in the first case, and old, new in the second.

// File: rtl/fnco_pkg.sv
package fnco_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_DIV    = 2'd1,
      SEL_INC_UP = 2'd2,
      SEL_INC_DN = 2'd3
   } fnco_sel_e;

   // coarse value = sequence steps + this offset
   localparam int COARSE_OFS = 3;
endpackage

// File: rtl/fnco_regs.sv
module fnco_regs
   import fnco_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int COARSE_W = 11,
   parameter int FINE_W   = 2,
   parameter int EN_BIT   = 31
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [1:0]                 wsel,
   input  logic [DATA_W-1:0]          wdata,
   input  logic [1:0]                 rsel,
   output logic [DATA_W-1:0]          rdata,
   output logic                       en,
   output logic [COARSE_W-1:0]        coarse,
   output logic [FINE_W-1:0]          fine,
   output logic signed [DATA_W-1:0]   inc_up,
   output logic signed [DATA_W-1:0]   inc_dn
);
   localparam int DIV_W = COARSE_W + FINE_W;

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= 1'b0;
         div_q  <= '0;
         inc_up <= '0;
         inc_dn <= '0;
      end else if (we) begin
         case (fnco_sel_e'(wsel))
            SEL_CTRL:   en     <= wdata[EN_BIT];
            SEL_DIV:    div_q  <= wdata[DIV_W-1:0];
            SEL_INC_UP: inc_up <= wdata;
            default:    inc_dn <= wdata;
         endcase
      end
   end

   assign fine   = div_q[FINE_W-1:0];
   assign coarse = div_q[DIV_W-1:FINE_W];

   always_comb begin
      rdata = '0;
      case (fnco_sel_e'(rsel))
         SEL_CTRL:   rdata[EN_BIT]      = en;
         SEL_DIV:    rdata[DIV_W-1:0]   = div_q;
         SEL_INC_UP: rdata              = inc_up;
         default:    rdata              = inc_dn;
      endcase
   end
endmodule

// File: rtl/fnco_timer.sv
module fnco_timer #(
   parameter int                COARSE_W = 11,
   parameter logic [COARSE_W:0] TAPS     = 12'hA01,
   parameter int                FINE_W   = 2,
   parameter int                TAIL_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [COARSE_W-1:0] load_state,
   input  logic [TAIL_W-1:0]   load_tail,
   output logic                expire,
   output logic [COARSE_W-1:0] state
);
   localparam logic [COARSE_W-1:0] FB = TAPS[COARSE_W:1];

   logic [COARSE_W-1:0] st_q, st_nxt;
   logic [FINE_W-1:0]   sub_q;
   logic [TAIL_W-1:0]   tail_q;
   logic                at_seed;

   // one right-shift step of the coarse sequence, built from the tap mask
   for (genvar b = 0; b < COARSE_W; b++) begin : g_fb
      if (b == COARSE_W-1) begin : g_msb
         assign st_nxt[b] = st_q[0] & FB[b];
      end else begin : g_lo
         assign st_nxt[b] = st_q[b+1] ^ (st_q[0] & FB[b]);
      end
   end

   assign at_seed = (st_q == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= '1;
         sub_q  <= '0;
         tail_q <= '0;
      end else if (load) begin
         st_q   <= load_state;
         sub_q  <= '1;
         tail_q <= load_tail;
      end else if (!at_seed) begin
         if (sub_q == '0) begin
            st_q  <= st_nxt;
            sub_q <= '1;
         end else begin
            sub_q <= sub_q - 1'b1;
         end
      end else if (tail_q != '0) begin
         tail_q <= tail_q - 1'b1;
      end
   end

   assign expire = at_seed && (tail_q == '0);
   assign state  = st_q;
endmodule

// File: rtl/fnco_dither.sv
module fnco_dither #(
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    advance,
   input  logic signed [ACC_W-1:0] inc_up,
   input  logic signed [ACC_W-1:0] inc_dn,
   output logic                    stretch,
   output logic signed [ACC_W-1:0] acc
);
   logic signed [ACC_W-1:0] step;

   assign stretch = !acc[ACC_W-1];
   assign step    = stretch ? inc_dn : inc_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       acc <= '0;
      else if (clear)   acc <= '0;
      else if (advance) acc <= acc + step;
   end
endmodule

// File: rtl/fnco_clkdiv.sv
module fnco_clkdiv
   import fnco_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                COARSE_W = 11,
   parameter int                FINE_W   = 2,
   parameter int                EN_BIT   = 31,
   parameter logic [COARSE_W:0] TAPS     = 12'hA01
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_wsel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [1:0]        reg_rsel,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              clk_out
);
   localparam int STEP      = 2 ** FINE_W;
   localparam int TAIL_W    = FINE_W + 2;
   localparam int TAIL_BASE = COARSE_OFS * STEP - 1;

   if (DATA_W <= COARSE_W + FINE_W || EN_BIT >= DATA_W) begin : g_bad_w
      $error("fnco_clkdiv: register width too small");
   end
   if (!TAPS[0] || !TAPS[COARSE_W]) begin : g_bad_taps
      $error("fnco_clkdiv: tap mask must span the full sequence width");
   end

   logic                       ctl_en;
   logic [COARSE_W-1:0]        div_coarse;
   logic [FINE_W-1:0]          div_fine;
   logic signed [DATA_W-1:0]   inc_up, inc_dn;
   logic                       tmr_expire, dth_stretch;
   logic [COARSE_W-1:0]        tmr_state;
   logic signed [DATA_W-1:0]   dth_acc;
   logic [TAIL_W-1:0]          tail_init;
   logic                       idle_q, out_q;
   logic                       cfg_ok, start, stop;

   fnco_regs #(
      .DATA_W(DATA_W), .COARSE_W(COARSE_W), .FINE_W(FINE_W), .EN_BIT(EN_BIT)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wsel(reg_wsel), .wdata(reg_wdata),
      .rsel(reg_rsel), .rdata(reg_rdata), .en(ctl_en), .coarse(div_coarse),
      .fine(div_fine), .inc_up(inc_up), .inc_dn(inc_dn)
   );

   // a usable setting: up >= 0, dn <= 0, not both zero, coarse state not stuck
   assign cfg_ok = !inc_up[DATA_W-1]
                 && (inc_dn[DATA_W-1] || inc_dn == '0)
                 && !(inc_up == '0 && inc_dn == '0)
                 && (div_coarse != '0);

   assign start = ctl_en && cfg_ok && (idle_q || tmr_expire);
   assign stop  = !ctl_en || (!idle_q && tmr_expire && !cfg_ok);

   assign tail_init = TAIL_W'(TAIL_BASE) + TAIL_W'(div_fine) + TAIL_W'(dth_stretch);

   fnco_dither #(.ACC_W(DATA_W)) i_dither (
      .clk(clk), .rst_n(rst_n), .clear(stop), .advance(start),
      .inc_up(inc_up), .inc_dn(inc_dn), .stretch(dth_stretch), .acc(dth_acc)
   );

   fnco_timer #(
      .COARSE_W(COARSE_W), .TAPS(TAPS), .FINE_W(FINE_W), .TAIL_W(TAIL_W)
   ) i_timer (
      .clk(clk), .rst_n(rst_n), .load(start), .load_state(div_coarse),
      .load_tail(tail_init), .expire(tmr_expire), .state(tmr_state)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= 1'b1;
         out_q  <= 1'b0;
      end else if (stop) begin
         idle_q <= 1'b1;
         out_q  <= 1'b0;
      end else if (start) begin
         idle_q <= 1'b0;
         if (!idle_q) out_q <= ~out_q;
      end
   end

   assign clk_out = out_q;
endmodule

// File: rtl/fnco_clkdiv_chk.sv
module fnco_clkdiv_chk #(
   parameter int DATA_W   = 32,
   parameter int COARSE_W = 11
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     en,
   input logic                     clk_out,
   input logic                     expire,
   input logic [COARSE_W-1:0]      lfsr_state,
   input logic signed [DATA_W-1:0] acc
);
   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !clk_out);

   a_r7_acc_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (acc == '0));

   a_r4_rise_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_out) |-> $past(expire));

   a_r6_state_live: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);
endmodule

bind fnco_clkdiv fnco_clkdiv_chk #(.DATA_W(DATA_W), .COARSE_W(COARSE_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .en(ctl_en), .clk_out(clk_out),
   .expire(tmr_expire), .lfsr_state(tmr_state), .acc(dth_acc)
);

// File: tb/test_fnco_clkdiv.sv
module test_fnco_clkdiv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_wsel = '0;
   logic [31:0] reg_wdata = '0;
   logic [1:0]  reg_rsel = '0;
   logic [31:0] reg_rdata;
   logic        clk_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fnco_clkdiv i_fnco_clkdiv (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wsel(reg_wsel),
      .reg_wdata(reg_wdata), .reg_rsel(reg_rsel), .reg_rdata(reg_rdata),
      .clk_out(clk_out)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // called at a negedge, returns one negedge later
   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [31:0] d);
      reg_rsel = sel;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [10:0] coarse_for(input int n);
      logic [10:0] s = 11'h7FF;
      for (int i = 0; i < 2047 - n; i++) s = {1'b0, s[10:1]} ^ (s[0] ? 11'h500 : 11'h000);
      return s;
   endfunction

   function automatic logic [31:0] div_word(input int n, input int fine);
      return {19'b0, coarse_for(n), 2'(fine)};
   endfunction

   task automatic next_toggle(output int gap);
      logic p = clk_out;
      int g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (clk_out == p && g < 5000);
      gap = g;
   endtask

   // programs a setting, enables, checks start latency and half-period lengths
   task automatic run_pattern(input string req, input int n, input int fine,
                              input int up, input int dn, input int count);
      longint acc = 0;
      int base = 4 * (n + 3) + fine;
      int l0, gap;
      bit lng;
      wr(2'd0, 32'h0);
      wr(2'd1, div_word(n, fine));
      wr(2'd2, 32'(up));
      wr(2'd3, 32'(dn));
      wr(2'd0, 32'h8000_0000);
      lng = (acc >= 0);
      acc += lng ? longint'(dn) : longint'(up);
      l0 = base + int'(lng);
      repeat (l0) @(negedge clk);
      check(clk_out == 1'b0, "R5", "low before first rise", clk_out, 0);
      @(negedge clk);
      check(clk_out == 1'b1, "R5", "first rise", clk_out, 1);
      for (int k = 1; k <= count; k++) begin
         lng = (acc >= 0);
         acc += lng ? longint'(dn) : longint'(up);
         next_toggle(gap);
         check(gap == base + int'(lng), req, "half-period length", gap, base + int'(lng));
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      check(clk_out == 1'b0, "R1", "clk_out in reset", clk_out, 0);
      for (int s = 0; s < 4; s++) begin
         rd(2'(s), d);
         check(d == 32'h0, "R1", "register after reset", d, 0);
      end
   endtask

   task automatic t_regmap;
      logic [31:0] d;
      wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d);
      check(d == 32'h8000_0000, "R2", "control readback", d, 32'h8000_0000);
      wr(2'd0, 32'h7FFF_FFFF); rd(2'd0, d);
      check(d == 32'h0, "R2", "control without enable", d, 0);
      wr(2'd1, 32'hFFFF_FFFF); rd(2'd1, d);
      check(d == 32'h0000_1FFF, "R2", "divider readback", d, 32'h1FFF);
      wr(2'd2, 32'h89AB_CDEF); rd(2'd2, d);
      check(d == 32'h89AB_CDEF, "R2", "up-increment readback", d, 32'h89AB_CDEF);
      wr(2'd3, 32'h1234_5678); rd(2'd3, d);
      check(d == 32'h1234_5678, "R2", "down-increment readback", d, 32'h1234_5678);
   endtask

   task automatic t_invalid(input string what, input logic [31:0] dv,
                            input int up, input int dn);
      int highs = 0;
      wr(2'd0, 32'h0);
      wr(2'd1, dv);
      wr(2'd2, 32'(up));
      wr(2'd3, 32'(dn));
      wr(2'd0, 32'h8000_0000);
      repeat (200) begin
         @(negedge clk);
         if (clk_out) highs++;
      end
      check(highs == 0, "R6", what, highs, 0);
   endtask

   task automatic t_disable;
      int g = 0;
      int highs = 0;
      while (!clk_out && g < 200) begin @(negedge clk); g++; end
      check(clk_out == 1'b1, "R7", "output high before disable", clk_out, 1);
      wr(2'd0, 32'h0);
      @(negedge clk);
      check(clk_out == 1'b0, "R7", "low two edges after disable", clk_out, 0);
      repeat (100) begin
         @(negedge clk);
         if (clk_out) highs++;
      end
      check(highs == 0, "R7", "stays low while disabled", highs, 0);
   endtask

   task automatic t_boundary;
      logic v0;
      int gap;
      // running with n=0, fine=0, always stretched: 13 cycles per half
      run_pattern("R8", 0, 0, 1, 0, 2);
      // write lands on the very edge that starts the next half
      v0 = clk_out;
      repeat (12) @(negedge clk);
      reg_we = 1'b1; reg_wsel = 2'd1; reg_wdata = div_word(0, 3);
      @(negedge clk);
      reg_we = 1'b0;
      check(clk_out != v0, "R8", "toggle at 13 despite write", clk_out, !v0);
      next_toggle(gap);
      check(gap == 13, "R8", "same-edge write not yet applied", gap, 13);
      next_toggle(gap);
      check(gap == 16, "R8", "same-edge write applied one half later", gap, 16);
      // write one edge before the start of the next half
      repeat (14) @(negedge clk);
      reg_we = 1'b1; reg_wsel = 2'd1; reg_wdata = div_word(0, 0);
      @(negedge clk);
      reg_we = 1'b0;
      next_toggle(gap);
      check(gap == 1, "R8", "current half keeps old length", gap, 1);
      next_toggle(gap);
      check(gap == 13, "R8", "early write applied at next half", gap, 13);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_regmap();
      t_invalid("negative up-increment", div_word(0, 0), -1, -1);
      t_invalid("positive down-increment", div_word(0, 0), 1, 1);
      t_invalid("both increments zero", div_word(0, 0), 0, 0);
      t_invalid("coarse state zero", 32'h0000_0001, 1, -1);
      run_pattern("R4 always stretched", 0, 0, 1, 0, 6);
      run_pattern("R3 coarse n=2 fine=3", 2, 3, 0, -5, 5);
      run_pattern("R4 one in two", 0, 1, 1, -1, 8);
      run_pattern("R3 R4 one in three n=5", 5, 2, 1, -2, 4);
      run_pattern("R7 restart from zero acc", 5, 2, 1, -2, 6);
      run_pattern("R4 full-range increments", 1, 0, 32'h7FFF_FFFF, 32'h8000_0000, 8);
      t_disable();
      t_boundary();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual expired expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule